// File: doc/BRIEF.md
# DSP reset boot-mode sequencer

This block brings the processor state up after reset is released. On the first clock edge after reset it captures three mode pins into the low bits of the operating-mode register. The two lowest captured bits, {MB, MA}, then pick one of four start-up paths. Mode 0 copies a boot image from external program memory into internal program RAM and then runs from address 0. Mode 1 reads a single probe word to choose a serial-port or host-port bootstrap source, flags that source, and holds the core off until an external completion input arrives. Mode 2 starts from the normal expanded-memory vector 0xE000. Mode 3 starts from 0x0000.

On every path the block finally loads the program counter and the reset vector. It also loads the status register, the stack pointer and the interrupt-priority register with their reset values, and it clears the upper control bits of the mode register. It then raises a one-cycle start strobe that tells the core it may begin fetching.

The sequencer is a single state machine. Its states are ST_LATCH, ST_COPY, ST_PROBE, ST_PWAIT, ST_INIT, ST_HOLD and ST_RUN, and ST_LATCH is the reset state. The transitions are:
- ST_LATCH goes to ST_COPY in mode 0, to ST_PROBE in mode 1, and to ST_INIT in modes 2 and 3.
- ST_COPY goes to ST_INIT once the last word has been read.
- ST_PROBE always goes to ST_PWAIT, and ST_PWAIT always goes to ST_INIT.
- ST_INIT goes to ST_HOLD in mode 1 and to ST_RUN otherwise.
- ST_HOLD goes to ST_RUN when the completion input is high.
- ST_RUN is left only by reset.

Top module: `boot_mode_seq`

## Requirements
- R1: On the first rising clock edge after reset is released, mode_pins[0], [1] and [2] are stored into omr_out bits 0 (MA), 1 (MB) and 2 (MC). Any later change on mode_pins has no effect on omr_out until the next reset.
- R2: In mode 0 the block issues 2048 reads, one per cycle, at addresses 0xC000+i for i from 0 to 2047. In the cycle after each read it writes the returned word to RAM address i. mem_rd_data is taken to hold the word read in the previous cycle.
- R3: At the end of mode 0, pc_out is 0, omr_out[1:0] is 2'b10 and reset_vec is 0xE000. start_done is high exactly one cycle after the last RAM write, which means 2050 clock edges after reset release.
- R4: In mode 1 the block makes exactly one read, at 0xC000. Bit 15 of the returned word selects the source: 1 raises boot_serial and 0 raises boot_host, and the two are never high together. The block then sets pc_out to 0, omr_out[1:0] to 2'b10 and reset_vec to 0xE000.
- R5: In mode 1, boot_active stays high and start_done stays low until boot_ext_done is sampled high while the block is waiting. start_done rises one cycle after that sample, and in the same cycle boot_active, boot_serial and boot_host fall.
- R6: In mode 2, pc_out and reset_vec are both 0xE000. start_done is high on the second clock edge after reset release.
- R7: In mode 3, pc_out and reset_vec are both 0x0000. omr_out[1:0] stays 2'b11, and start_done is high on the second clock edge after reset release.
- R8: When start_done is high:
  - sr_out is 0x0300, with mask bits 9:8 set and every other bit clear;
  - sp_out is 0;
  - ipr_out is 0;
  - omr_out bits 7:4 are 0;
  - omr_out bit 2 still holds the latched MC value.
- R9: start_done is a single-cycle pulse, and it occurs once per reset release.
- R10: No RAM write happens outside mode 0. Modes 2 and 3 issue no memory read at all.
- R11: While reset is held, the outputs are as follows:
  - pc_out and reset_vec are 0;
  - sr_out is 0x0300;
  - omr_out, sp_out and ipr_out are 0;
  - start_done, boot_active, mem_rd_en and ram_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 3 | Mode pins: bit 0 is MA, bit 1 is MB, bit 2 is MC |
| boot_ext_done | input | 1 | Completion of the external bootstrap transfer |
| mem_rd_en | output | 1 | External program memory read strobe |
| mem_rd_addr | output | 16 | External program memory read address |
| mem_rd_data | input | 16 | Word returned for the read of the previous cycle |
| ram_wr_en | output | 1 | Internal program RAM write strobe |
| ram_wr_addr | output | 11 | Internal program RAM write address |
| ram_wr_data | output | 16 | Internal program RAM write data |
| pc_out | output | 16 | Initial program counter |
| reset_vec | output | 16 | Reset vector |
| sr_out | output | 16 | Status register |
| omr_out | output | 16 | Operating-mode register |
| sp_out | output | 6 | Stack pointer |
| ipr_out | output | 16 | Interrupt-priority register |
| boot_active | output | 1 | Mode 1 bootstrap in progress |
| boot_serial | output | 1 | Active bootstrap source is the serial port |
| boot_host | output | 1 | Active bootstrap source is the host port |
| start_done | output | 1 | One-cycle strobe: the core may begin fetching |

## Verification
The assertions take for granted that the external memory answers every read with fixed, one-cycle-late data. They also assume that boot_ext_done matters only while boot_active is high. The bench memory model supplies read data on the falling edge after each read strobe, so the data is stable in the following cycle. The word at each address is a pure function of the address plus a chosen probe bit. The completion input is raised only after boot_active has been seen for at least one cycle, and it is held high until the start strobe appears. The mode pins are randomised right after the capture edge and again after the start strobe, to exercise R1.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [2:0] {
        ST_LATCH = 3'd0,
        ST_COPY  = 3'd1,
        ST_PROBE = 3'd2,
        ST_PWAIT = 3'd3,
        ST_INIT  = 3'd4,
        ST_HOLD  = 3'd5,
        ST_RUN   = 3'd6
    } seq_state_t;

    // Operating modes as {MB, MA}
    localparam logic [1:0] MODE_COPY   = 2'd0;
    localparam logic [1:0] MODE_PROBE  = 2'd1;
    localparam logic [1:0] MODE_NORMAL = 2'd2;
    localparam logic [1:0] MODE_DEVEL  = 2'd3;

    localparam int OMR_W   = 8;
    localparam int SR_W    = 16;
    localparam int IMASK_LO = 8;

    function automatic logic [SR_W-1:0] sr_reset_value();
        logic [SR_W-1:0] v;
        v = '0;
        v[IMASK_LO]   = 1'b1;
        v[IMASK_LO+1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bootseq_omr.sv
module bootseq_omr
    import bootseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [2:0]       pins,
    input  logic             init,
    input  logic             force_normal,
    output logic [OMR_W-1:0] omr
);

    logic [OMR_W-1:0] omr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            omr_q <= '0;
        end else begin
            if (capture) begin
                omr_q[2:0] <= pins;
            end
            if (init) begin
                omr_q[7:4] <= 4'b0000;
                omr_q[3]   <= 1'b0;
            end
            if (force_normal) begin
                omr_q[1:0] <= MODE_NORMAL;
            end
        end
    end

    assign omr = omr_q;

endmodule

// File: rtl/bootseq_copier.sv
module bootseq_copier #(
    parameter int ADDR_W     = 16,
    parameter int RAM_AW     = 11,
    parameter int COPY_WORDS = 2048,
    parameter logic [ADDR_W-1:0] SRC_BASE = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              last,
    output logic              wr_en,
    output logic [RAM_AW-1:0] wr_addr
);

    localparam int CNT_W = (COPY_WORDS > 1) ? $clog2(COPY_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(COPY_WORDS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic [RAM_AW-1:0] waddr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            waddr_q <= '0;
        end else begin
            pend_q <= run;
            if (run) begin
                waddr_q <= RAM_AW'(cnt_q);
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign rd_addr = SRC_BASE + ADDR_W'(cnt_q);
    assign last    = run && (cnt_q == LAST_CNT);
    assign wr_en   = pend_q;
    assign wr_addr = waddr_q;

endmodule

// File: rtl/bootseq_regs.sv
module bootseq_regs
    import bootseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SP_W   = 6,
    parameter int IPR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] vec_val,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] vec,
    output logic [SR_W-1:0]   sr,
    output logic [SP_W-1:0]   sp,
    output logic [IPR_W-1:0]  ipr
);

    logic [ADDR_W-1:0] pc_q, vec_q;
    logic [SR_W-1:0]   sr_q;
    logic [SP_W-1:0]   sp_q;
    logic [IPR_W-1:0]  ipr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            vec_q <= '0;
            sr_q  <= sr_reset_value();
            sp_q  <= '0;
            ipr_q <= '0;
        end else if (load) begin
            pc_q  <= pc_val;
            vec_q <= vec_val;
            sr_q  <= sr_reset_value();
            sp_q  <= '0;
            ipr_q <= '0;
        end
    end

    assign pc  = pc_q;
    assign vec = vec_q;
    assign sr  = sr_q;
    assign sp  = sp_q;
    assign ipr = ipr_q;

endmodule

// File: rtl/boot_mode_seq.sv
module boot_mode_seq
    import bootseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int RAM_AW     = 11,
    parameter int SP_W       = 6,
    parameter int IPR_W      = 16,
    parameter int COPY_WORDS = 2048,
    parameter logic [ADDR_W-1:0] SRC_BASE   = 16'hC000,
    parameter logic [ADDR_W-1:0] NORMAL_VEC = 16'hE000,
    parameter logic [ADDR_W-1:0] DEVEL_VEC  = 16'h0000,
    parameter logic [ADDR_W-1:0] BOOT_PC    = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_pins,
    input  logic              boot_ext_done,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              ram_wr_en,
    output logic [RAM_AW-1:0] ram_wr_addr,
    output logic [DATA_W-1:0] ram_wr_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] reset_vec,
    output logic [15:0]       sr_out,
    output logic [15:0]       omr_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [IPR_W-1:0]  ipr_out,
    output logic              boot_active,
    output logic              boot_serial,
    output logic              boot_host,
    output logic              start_done
);

    seq_state_t state_q, state_d;

    logic [OMR_W-1:0]  omr;
    logic [1:0]        cur_mode;
    logic [1:0]        pin_mode;
    logic              copy_run, copy_last;
    logic [ADDR_W-1:0] copy_addr;
    logic              load_regs;
    logic [ADDR_W-1:0] pc_sel, vec_sel;
    logic              src_q, active_q, done_q;
    logic              capture, force_normal, release_hold;

    assign cur_mode = omr[1:0];
    assign pin_mode = mode_pins[1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LATCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LATCH: begin
                unique case (pin_mode)
                    MODE_COPY:  state_d = ST_COPY;
                    MODE_PROBE: state_d = ST_PROBE;
                    default:    state_d = ST_INIT;
                endcase
            end
            ST_COPY:  if (copy_last) state_d = ST_INIT;
            ST_PROBE: state_d = ST_PWAIT;
            ST_PWAIT: state_d = ST_INIT;
            ST_INIT:  state_d = (cur_mode == MODE_PROBE) ? ST_HOLD : ST_RUN;
            ST_HOLD:  if (boot_ext_done) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_LATCH;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        capture      = (state_q == ST_LATCH);
        copy_run     = (state_q == ST_COPY);
        load_regs    = (state_q == ST_INIT);
        force_normal = (state_q == ST_INIT) && !cur_mode[1];
        release_hold = (state_q == ST_HOLD) && boot_ext_done;
        mem_rd_en    = copy_run || (state_q == ST_PROBE);
        mem_rd_addr  = copy_run ? copy_addr : SRC_BASE;
        unique case (cur_mode)
            MODE_NORMAL: begin pc_sel = NORMAL_VEC; vec_sel = NORMAL_VEC; end
            MODE_DEVEL:  begin pc_sel = DEVEL_VEC;  vec_sel = DEVEL_VEC;  end
            default:     begin pc_sel = BOOT_PC;    vec_sel = NORMAL_VEC; end
        endcase
    end

    // Bootstrap flags and start strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= 1'b0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (state_q == ST_PWAIT) begin
                src_q    <= mem_rd_data[DATA_W-1];
                active_q <= 1'b1;
            end else if (release_hold) begin
                active_q <= 1'b0;
            end
            done_q <= (load_regs && (cur_mode != MODE_PROBE)) || release_hold;
        end
    end

    bootseq_omr u_omr (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .pins         (mode_pins),
        .init         (load_regs),
        .force_normal (force_normal),
        .omr          (omr)
    );

    bootseq_copier #(
        .ADDR_W     (ADDR_W),
        .RAM_AW     (RAM_AW),
        .COPY_WORDS (COPY_WORDS),
        .SRC_BASE   (SRC_BASE)
    ) u_copier (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (copy_run),
        .rd_addr (copy_addr),
        .last    (copy_last),
        .wr_en   (ram_wr_en),
        .wr_addr (ram_wr_addr)
    );

    bootseq_regs #(
        .ADDR_W (ADDR_W),
        .SP_W   (SP_W),
        .IPR_W  (IPR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_regs),
        .pc_val  (pc_sel),
        .vec_val (vec_sel),
        .pc      (pc_out),
        .vec     (reset_vec),
        .sr      (sr_out),
        .sp      (sp_out),
        .ipr     (ipr_out)
    );

    assign ram_wr_data = mem_rd_data;
    assign omr_out     = {{(16 - OMR_W){1'b0}}, omr};
    assign boot_active = active_q;
    assign boot_serial = active_q && src_q;
    assign boot_host   = active_q && !src_q;
    assign start_done  = done_q;

endmodule

// File: rtl/boot_mode_seq_chk.sv
module boot_mode_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_en,
    input logic        ram_wr_en,
    input logic [10:0] ram_wr_addr,
    input logic [15:0] pc_out,
    input logic [15:0] reset_vec,
    input logic [15:0] sr_out,
    input logic [15:0] omr_out,
    input logic [5:0]  sp_out,
    input logic [15:0] ipr_out,
    input logic        boot_active,
    input logic        boot_serial,
    input logic        boot_host,
    input logic        start_done
);

    logic ran_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ran_q <= 1'b0;
        else if (start_done) ran_q <= 1'b1;
    end

    // R2
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(mem_rd_en));

    // R2
    write_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && $past(ram_wr_en)) |-> (ram_wr_addr == $past(ram_wr_addr) + 11'd1));

    // R4
    boot_src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_serial, boot_host}) && ((boot_serial || boot_host) == boot_active));

    // R5
    hold_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_active |-> !start_done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_done);

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ran_q |-> !start_done);

    // R1
    omr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ran_q |-> ($stable(omr_out) && $stable(pc_out) && $stable(reset_vec)));

    // R8
    init_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> (sr_out == 16'h0300 && sp_out == 6'd0 && ipr_out == 16'd0
                        && omr_out[7:3] == 5'd0 && omr_out[1]));

    // R7
    devel_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_done && omr_out[0]) |-> (pc_out == 16'h0000 && reset_vec == 16'h0000));

    // R6
    normal_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_done && !omr_out[0]) |-> (reset_vec == 16'hE000));

endmodule

bind boot_mode_seq boot_mode_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd_en   (mem_rd_en),
    .ram_wr_en   (ram_wr_en),
    .ram_wr_addr (ram_wr_addr),
    .pc_out      (pc_out),
    .reset_vec   (reset_vec),
    .sr_out      (sr_out),
    .omr_out     (omr_out),
    .sp_out      (sp_out),
    .ipr_out     (ipr_out),
    .boot_active (boot_active),
    .boot_serial (boot_serial),
    .boot_host   (boot_host),
    .start_done  (start_done)
);

// File: tb/test_boot_mode_seq.sv
`timescale 1ns/1ps
module test_boot_mode_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_pins = 3'b000;
    logic        boot_ext_done = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data = 16'h0000;
    logic        ram_wr_en;
    logic [10:0] ram_wr_addr;
    logic [15:0] ram_wr_data;
    logic [15:0] pc_out, reset_vec, sr_out, omr_out, ipr_out;
    logic [5:0]  sp_out;
    logic        boot_active, boot_serial, boot_host, start_done;

    always #2.5 clk = ~clk;

    boot_mode_seq i_boot_mode_seq (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .boot_ext_done(boot_ext_done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
        .pc_out(pc_out), .reset_vec(reset_vec), .sr_out(sr_out), .omr_out(omr_out),
        .sp_out(sp_out), .ipr_out(ipr_out), .boot_active(boot_active),
        .boot_serial(boot_serial), .boot_host(boot_host), .start_done(start_done)
    );

    int          checks = 0;
    int          errors = 0;
    logic        probe_bit = 1'b0;
    logic [15:0] salt = 16'h3A5C;
    logic [15:0] ram_img [2048];
    logic        ram_hit [2048];
    int          rd_count = 0;
    int          wr_count = 0;
    int          wr_dup = 0;

    function automatic logic [15:0] word_at(input logic [15:0] a, input logic pb,
                                             input logic [15:0] s);
        logic [15:0] w;
        w = (a * 16'h9E37) ^ s;
        if (a == 16'hC000) w[15] = pb;
        return w;
    endfunction

    function automatic logic [15:0] exp_omr(input int m, input logic mc);
        logic [15:0] v;
        v = 16'h0000;
        v[2] = mc;
        v[1:0] = (m < 2) ? 2'b10 : 2'(m);
        return v;
    endfunction

    function automatic logic [15:0] exp_pc(input int m);
        return (m == 2) ? 16'hE000 : 16'h0000;
    endfunction

    function automatic logic [15:0] exp_vec(input int m);
        return (m == 3) ? 16'h0000 : 16'hE000;
    endfunction

    // Memory and RAM models, evaluated away from the active edge
    always @(negedge clk) begin
        if (ram_wr_en) begin
            if (ram_hit[ram_wr_addr]) wr_dup = wr_dup + 1;
            ram_hit[ram_wr_addr] = 1'b1;
            ram_img[ram_wr_addr] = ram_wr_data;
            wr_count = wr_count + 1;
        end
        if (mem_rd_en) begin
            rd_count = rd_count + 1;
            mem_rd_data <= word_at(mem_rd_addr, probe_bit, salt);
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int m, input logic mc, input logic pb, input int hold);
        int edges;
        int done_edge;
        int raise_edge;
        int done_hi;
        logic [15:0] omr_at_done;
        logic seen_src;
        rst_n = 1'b0;
        boot_ext_done = 1'b0;
        probe_bit = pb;
        mode_pins = {mc, 2'(m)};
        for (int i = 0; i < 2048; i++) begin ram_hit[i] = 1'b0; ram_img[i] = 16'h0; end
        repeat (3) @(negedge clk);
        rd_count = 0; wr_count = 0; wr_dup = 0;
        // R11 reset state
        chk(pc_out == 16'h0 && reset_vec == 16'h0, "R11", "pc/vec in reset", {pc_out, reset_vec}, 32'h0);
        chk(sr_out == 16'h0300 && omr_out == 16'h0 && sp_out == 6'd0 && ipr_out == 16'h0,
            "R11", "sr/omr/sp/ipr in reset", {sr_out, omr_out}, 32'h03000000);
        chk(!start_done && !boot_active && !mem_rd_en && !ram_wr_en, "R11", "strobes in reset",
            {28'h0, start_done, boot_active, mem_rd_en, ram_wr_en}, 32'h0);
        rst_n = 1'b1;
        edges = 0; done_edge = -1; raise_edge = -1; done_hi = 0; seen_src = 1'b0;
        omr_at_done = 16'h0;
        while (done_edge < 0 && edges < 3000) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
            if (edges == 1) mode_pins = 3'($urandom);  // R1 pins ignored after capture
            if (start_done) begin done_edge = edges; omr_at_done = omr_out; end
            if (m == 1 && boot_active && !seen_src) begin
                seen_src = 1'b1;
                chk(boot_serial == pb && boot_host == !pb, "R4", "source flags",
                    {30'h0, boot_serial, boot_host}, {30'h0, pb, !pb});
                repeat (hold) begin
                    @(posedge clk); @(negedge clk); edges++;
                    if (start_done) done_hi++;
                end
                chk(boot_active && done_hi == 0, "R5", "held off before completion",
                    {31'h0, boot_active}, 32'h1);
                boot_ext_done = 1'b1;
                raise_edge = edges;
            end
        end
        boot_ext_done = 1'b0;
        chk(done_edge > 0, "R9", "start strobe seen", done_edge, 1);
        if (m == 0) chk(done_edge == 2050, "R3", "copy finish edge", done_edge, 2050);
        if (m == 1) chk(done_edge == raise_edge + 1, "R5", "done after completion", done_edge, raise_edge + 1);
        if (m == 1) chk(!boot_active && !boot_serial && !boot_host, "R5", "flags cleared",
                        {29'h0, boot_active, boot_serial, boot_host}, 32'h0);
        if (m == 2) chk(done_edge == 2, "R6", "normal finish edge", done_edge, 2);
        if (m == 3) chk(done_edge == 2, "R7", "devel finish edge", done_edge, 2);
        chk(pc_out == exp_pc(m), (m == 2) ? "R6" : (m == 3) ? "R7" : (m == 0) ? "R3" : "R4",
            "pc", pc_out, exp_pc(m));
        chk(reset_vec == exp_vec(m), (m == 3) ? "R7" : (m == 2) ? "R6" : "R4", "vector",
            reset_vec, exp_vec(m));
        chk(omr_at_done == exp_omr(m, mc), "R1", "omr at start", omr_at_done, exp_omr(m, mc));
        chk(sr_out == 16'h0300 && sp_out == 6'd0 && ipr_out == 16'h0, "R8", "register init",
            {sr_out, 10'h0, sp_out}, 32'h03000000);
        mode_pins = 3'($urandom);
        @(negedge clk);
        chk(!start_done, "R9", "strobe one cycle", {31'h0, start_done}, 32'h0);
        repeat (6) begin
            @(negedge clk);
            if (start_done) done_hi++;
            mode_pins = 3'($urandom);
        end
        chk(done_hi == 0, "R9", "no second strobe", done_hi, 0);
        chk(omr_out == exp_omr(m, mc), "R1", "omr ignores pins", omr_out, exp_omr(m, mc));
        if (m == 0) begin
            int bad;
            int first_bad;
            bad = 0; first_bad = -1;
            for (int i = 0; i < 2048; i++) begin
                if (!ram_hit[i] || ram_img[i] != word_at(16'hC000 + 16'(i), pb, salt)) begin
                    bad++;
                    if (first_bad < 0) first_bad = i;
                end
            end
            chk(bad == 0, "R2", "ram image mismatches", bad, 0);
            chk(wr_count == 2048 && wr_dup == 0 && rd_count == 2048, "R2", "copy counts",
                wr_count, 2048);
        end else begin
            chk(wr_count == 0, "R10", "no ram writes", wr_count, 0);
            chk(rd_count == ((m == 1) ? 1 : 0), "R10", "read count", rd_count, (m == 1) ? 1 : 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Directed corners
        run_case(0, 1'b0, 1'b0, 1);
        run_case(1, 1'b1, 1'b1, 1);
        run_case(1, 1'b0, 1'b0, 5);
        run_case(2, 1'b1, 1'b0, 1);
        run_case(3, 1'b0, 1'b1, 1);
        // Random cases
        for (int k = 0; k < 8; k++) begin
            int m;
            m = int'($urandom % 4);
            if (m == 0 && k > 3) m = 2;
            salt = 16'($urandom);
            run_case(m, 1'($urandom), 1'($urandom), 1 + int'($urandom % 8));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule